// File: doc/BRIEF.md
# Memory Browse and Edit Controller

This block sits in front of a small memory of 16 bytes and gives it a
three-button interface. One pointer picks the location to view. It moves one
step forward or back on each pulse and wraps at both ends. A separate pulse
writes an operator-supplied byte to an operator-supplied address, and that
address does not have to be the one being viewed. The viewed location drives
a four-digit hexadecimal readout. The top digit shows the location, a blanked
digit separates it from the data, and the bottom two digits show the data.

After reset the controller is in state CLEAR. It uses the write port to sweep
zeros through every location, one per cycle in ascending order. It then moves
to state BROWSE and stays there until the next reset. CLEAR has one
transition, CLEAR->BROWSE, which is taken when the last address has been
cleared. BROWSE has no outgoing transition apart from reset. Operator pulses
that arrive during CLEAR are dropped. The seven-segment decoder and scanner,
and the button debouncing, belong to the surrounding logic.

Top module: `membrowse_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the view pointer at 0 and enters CLEAR. In CLEAR the write port is enabled on every cycle with data 0, at addresses 0,1,...,15 on successive cycles. The CLEAR->BROWSE transition follows the cycle that writes address 15.
- R2: After CLEAR, every location reads 0 on the display until it is written.
- R3: step_next, step_prev and store_pulse have no effect during CLEAR. The pointer stays at 0 and no operator data reaches the memory.
- R4: In BROWSE, step_next alone advances the pointer by one on the next clock, and 15 wraps to 0.
- R5: In BROWSE, step_prev alone moves the pointer back by one on the next clock, and 0 wraps to 15.
- R6: When step_next and step_prev are high in the same cycle, the pointer does not move.
- R7: In BROWSE, mem_we equals store_pulse in the same cycle, with mem_waddr = sw_addr and mem_wdata = sw_data. One write pulse gives exactly one enabled clock.
- R8: A write to a location other than the viewed one changes neither view_addr nor the displayed digits.
- R9: disp_digits[15:12] holds the view pointer. disp_digits[11:8] is 0 and flagged blank, so disp_blank = 4'b0100. disp_digits[7:4] holds the high nibble of the viewed data and disp_digits[3:0] holds the low nibble.
- R10: A write to the viewed location appears on the display in the cycle after the pulse. For example, writing 0xFF to location 15 while viewing it gives digits F, blank, F, F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_next | input | 1 | One-cycle pulse: move the view forward |
| step_prev | input | 1 | One-cycle pulse: move the view back |
| store_pulse | input | 1 | One-cycle pulse: write sw_data to sw_addr |
| sw_data | input | 8 | Byte to be written |
| sw_addr | input | 4 | Location to be written |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | 4 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| view_addr | output | 4 | Display read address (view pointer) |
| disp_digits | output | 16 | Four hex digit codes, most significant digit first |
| disp_blank | output | 4 | Per-digit blank flags |

## Verification
The bench builds the block with its default widths: a 4-bit address and 8-bit
data. With these widths the zeroing sweep finishes in 16 cycles, and a wrap in
either direction is at most 16 pulses away. Both wraps, the coincident-pulse
hold and writes to the viewed and to an unviewed location are all reached
within a few hundred cycles. A random phase then mixes all three pulses,
including writes landing in the same cycle as pointer moves.

// File: rtl/mbe_pkg.sv
package mbe_pkg;

    typedef enum logic [0:0] {
        ST_CLEAR  = 1'b0,
        ST_BROWSE = 1'b1
    } mbe_state_e;

    // hex digits needed to show a field of the given width
    function automatic int hex_digits(input int bits);
        return (bits + 3) / 4;
    endfunction

endpackage

// File: rtl/mbe_view_ptr.sv
module mbe_view_ptr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              step_up,
    input  logic              step_dn,
    output logic [ADDR_W-1:0] ptr
);

    logic go_up;
    logic go_dn;

    assign go_up = en && step_up && !step_dn;
    assign go_dn = en && step_dn && !step_up;

    // power-of-two depth: natural overflow gives the wrap in both directions
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (go_up)
            ptr <= ptr + 1'b1;
        else if (go_dn)
            ptr <= ptr - 1'b1;
    end

    // R4
    ptr_up_chk: assert property (@(posedge clk) disable iff (rst)
        (en && step_up && !step_dn) |=> (ptr == $past(ptr) + 1'b1));

    // R5
    ptr_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (en && step_dn && !step_up) |=> (ptr == $past(ptr) - 1'b1));

    // R6
    ptr_tie_chk: assert property (@(posedge clk) disable iff (rst)
        (step_up && step_dn) |=> $stable(ptr));

endmodule

// File: rtl/mbe_store.sv
module mbe_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

    // R10
    store_land_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (cells[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/mbe_digit_pack.sv
module mbe_digit_pack
    import mbe_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [4*(hex_digits(ADDR_W) + 1 + hex_digits(DATA_W))-1:0] digits,
    output logic [hex_digits(ADDR_W) + 1 + hex_digits(DATA_W)-1:0]     blank
);

    localparam int ADDR_DIG = hex_digits(ADDR_W);
    localparam int DATA_DIG = hex_digits(DATA_W);
    localparam int GAP_POS  = DATA_DIG;

    logic [4*ADDR_DIG-1:0] addr_ext;
    logic [4*DATA_DIG-1:0] data_ext;

    assign addr_ext = (4*ADDR_DIG)'(addr);
    assign data_ext = (4*DATA_DIG)'(data);

    // data digits at the bottom
    for (genvar i = 0; i < DATA_DIG; i++) begin : g_data
        assign digits[4*i +: 4] = data_ext[4*i +: 4];
        assign blank[i]         = 1'b0;
    end

    // one dark digit separating the fields
    assign digits[4*GAP_POS +: 4] = 4'h0;
    assign blank[GAP_POS]         = 1'b1;

    // address digits on top
    for (genvar j = 0; j < ADDR_DIG; j++) begin : g_addr
        assign digits[4*(GAP_POS+1+j) +: 4] = addr_ext[4*j +: 4];
        assign blank[GAP_POS+1+j]           = 1'b0;
    end

endmodule

// File: rtl/membrowse_ctrl.sv
module membrowse_ctrl
    import mbe_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_next,
    input  logic              step_prev,
    input  logic              store_pulse,
    input  logic [DATA_W-1:0] sw_data,
    input  logic [ADDR_W-1:0] sw_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] view_addr,
    output logic [4*(hex_digits(ADDR_W) + 1 + hex_digits(DATA_W))-1:0] disp_digits,
    output logic [hex_digits(ADDR_W) + 1 + hex_digits(DATA_W)-1:0]     disp_blank
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    mbe_state_e        state_q, state_d;
    logic [ADDR_W-1:0] clr_cnt_q, clr_cnt_d;
    logic              ptr_en;
    logic [DATA_W-1:0] view_data;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_CLEAR;
            clr_cnt_q <= '0;
        end else begin
            state_q   <= state_d;
            clr_cnt_q <= clr_cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d   = state_q;
        clr_cnt_d = clr_cnt_q;
        unique case (state_q)
            ST_CLEAR: begin
                clr_cnt_d = clr_cnt_q + 1'b1;
                if (clr_cnt_q == LAST_ADDR)
                    state_d = ST_BROWSE;
            end
            ST_BROWSE: begin
                state_d = ST_BROWSE;
            end
        endcase
    end

    // outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = '0;
        mem_wdata = '0;
        ptr_en    = 1'b0;
        unique case (state_q)
            ST_CLEAR: begin
                mem_we    = 1'b1;
                mem_waddr = clr_cnt_q;
                mem_wdata = '0;
            end
            ST_BROWSE: begin
                mem_we    = store_pulse;
                mem_waddr = sw_addr;
                mem_wdata = sw_data;
                ptr_en    = 1'b1;
            end
        endcase
    end

    mbe_view_ptr #(.ADDR_W(ADDR_W)) i_ptr (
        .clk     (clk),
        .rst     (rst),
        .en      (ptr_en),
        .step_up (step_next),
        .step_dn (step_prev),
        .ptr     (view_addr)
    );

    mbe_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (view_addr),
        .rdata (view_data)
    );

    mbe_digit_pack #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pack (
        .addr   (view_addr),
        .data   (view_data),
        .digits (disp_digits),
        .blank  (disp_blank)
    );

    // R1
    clear_sweep_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CLEAR) |=>
            ((state_q == ST_BROWSE) || (clr_cnt_q == $past(clr_cnt_q) + 1'b1)));

    // R3
    clear_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CLEAR) |=> $stable(view_addr));

endmodule

// File: tb/test_membrowse_ctrl.sv
module test_membrowse_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        step_next, step_prev, store_pulse;
    logic [7:0]  sw_data;
    logic [3:0]  sw_addr;
    logic        mem_we;
    logic [3:0]  mem_waddr;
    logic [7:0]  mem_wdata;
    logic [3:0]  view_addr;
    logic [15:0] disp_digits;
    logic [3:0]  disp_blank;

    always #4 clk = ~clk;

    membrowse_ctrl i_membrowse_ctrl (
        .clk(clk), .rst(rst),
        .step_next(step_next), .step_prev(step_prev), .store_pulse(store_pulse),
        .sw_data(sw_data), .sw_addr(sw_addr),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .view_addr(view_addr), .disp_digits(disp_digits), .disp_blank(disp_blank)
    );

    int    vectors = 0;
    int    miscompares = 0;
    // behavioural reference
    int    m_ptr, m_clr;
    bit    m_clear;
    int    m_mem[16];
    string ptr_tag = "R1";
    string dat_tag = "R2";

    task automatic chk(string tag, string what, int act, int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // call at a falling edge; leaves at the next falling edge
    task automatic cyc(bit nx, bit pv, bit wr, int a, int d);
        step_next = nx; step_prev = pv; store_pulse = wr;
        sw_addr = 4'(a); sw_data = 8'(d);
        #1;
        if (m_clear) begin
            chk("R1", "mem_we", int'(mem_we), 1);
            chk("R1", "mem_waddr", int'(mem_waddr), m_clr);
            chk("R1", "mem_wdata", int'(mem_wdata), 0);
        end else begin
            chk("R7", "mem_we", int'(mem_we), int'(wr));
            if (wr) begin
                chk("R7", "mem_waddr", int'(mem_waddr), a);
                chk("R7", "mem_wdata", int'(mem_wdata), d);
            end
        end
        chk(ptr_tag, "view_addr", int'(view_addr), m_ptr);
        if (!m_clear) begin
            chk("R9", "addr digit", int'(disp_digits[15:12]), m_ptr);
            chk("R9", "gap digit", int'(disp_digits[11:8]), 0);
            chk("R9", "disp_blank", int'(disp_blank), 4);
            chk(dat_tag, "data digits", int'(disp_digits[7:0]), m_mem[m_ptr]);
        end
        @(posedge clk);
        if (m_clear) begin
            ptr_tag = (nx || pv) ? "R3" : "R1";
            dat_tag = wr ? "R3" : "R2";
            if (m_clr == 15) m_clear = 0;
            m_clr++;
        end else begin
            if (nx && pv)      ptr_tag = "R6";
            else if (pv)       ptr_tag = "R5";
            else               ptr_tag = "R4";
            if (nx && !pv) m_ptr = (m_ptr + 1) % 16;
            if (pv && !nx) m_ptr = (m_ptr + 15) % 16;
            if (wr) begin
                m_mem[a] = d & 255;
                dat_tag = (a == m_ptr) ? "R10" : "R8";
            end else
                dat_tag = "R2";
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst = 1'b1;
        step_next = 0; step_prev = 0; store_pulse = 0; sw_addr = 0; sw_data = 0;
        repeat (3) @(negedge clk);
        chk("R1", "view_addr in reset", int'(view_addr), 0);
        rst = 1'b0;
        m_ptr = 0; m_clr = 0; m_clear = 1;
        for (int i = 0; i < 16; i++) m_mem[i] = 0;

        // R1 sweep with R3 operator pulses that must be dropped
        for (int i = 0; i < 16; i++)
            cyc(i % 3 == 0, i % 5 == 1, i % 2 == 0, 5, 8'hAA);

        // R2 all locations zero, R4 forward wrap
        for (int i = 0; i < 17; i++) cyc(1, 0, 0, 0, 0);

        // R8 write elsewhere while viewing location 1
        cyc(0, 0, 1, 3, 8'h12);
        cyc(0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);

        // R5 backward through 0 to 15
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);

        // R10 write 0xFF to viewed location 15
        cyc(0, 0, 1, 15, 8'hFF);
        cyc(0, 0, 0, 0, 0);

        // R6 coincident steps
        cyc(1, 1, 0, 0, 0);
        cyc(1, 1, 1, 15, 8'h3C);
        cyc(0, 0, 0, 0, 0);

        // write and move together
        cyc(1, 0, 1, 0, 8'h77);
        cyc(0, 1, 1, 0, 8'h55);
        cyc(0, 0, 0, 0, 0);

        // mixed random traffic
        for (int i = 0; i < 300; i++)
            cyc(($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 3) == 0,
                int'($urandom % 16), int'($urandom % 256));
        cyc(0, 0, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule